// File: doc/BRIEF.md
# Serial Neuron Multiply-Accumulate Unit

This block evaluates one neuron of a feed-forward network. A start pulse launches a run over N synapses. For each synapse the block reads the input activation and then its weight through one single-port memory port. It multiplies the pair and adds the product to a running sum. The sum was preloaded with the neuron's bias. After the last product has been added, a bounded, monotonic, sigmoid-shaped transfer function maps the top bits of the sum to an 8-bit output. The block raises a one-cycle done pulse with that output.

Memory reads, multiplication and accumulation overlap in a three-stage pipeline. The single port carries one read per cycle, so a run of N synapses occupies the port for 2N cycles. The multiplier and the adder each see a new operand every second cycle. Memory data goes straight into the multiplier, and only the activation is held while its weight is being read.

Top module: `neuron_mac`

## Requirements
- R1: After reset, busy_o, done_o and mem_rd_o are 0 and y_o is 0.
- R2: A run over N synapses asserts mem_rd_o for exactly 2N consecutive cycles, starting in the cycle after the accepted start edge, with mem_addr_o counting 0, 1, ..., 2N-1. The activation of synapse k sits at address 2k and its weight at address 2k+1. The memory returns the data one clock after the read.
- R3: Activations and weights are 8-bit two's complement. The net sum is the signed 16-bit bias_i plus the sum of the full-precision products.
- R4: Each product is added to the held sum in synapse order, and the sum is clamped after every addition to the range -32768..32767. A later negative product therefore starts from the clamped value, not from a wrapped value.
- R5: Let v be bits 15:10 of the final sum, read as signed (-32..31), and let a = |v|. The magnitude m is 12a for a<8, 96+3(a-8) for 8<=a<16, and 120+((a-16)>>1) otherwise. y = 128+m for v>=0 and y = 128-m for v<0.
- R6: For N>=1, done_o is high for exactly one cycle, 2N+3 clock edges after the edge that accepted start. y_o takes its new value on that same edge and holds it until the next done pulse.
- R7: With N=0 the block makes no memory reads. done_o rises one edge after the start edge, and y_o is the transfer of the bias alone.
- R8: A start_i pulse while busy_o is high is ignored. The read sequence, the done timing and y_o of the run in progress are unchanged.
- R9: An n_inputs_i value above MAX_IN (16) is treated as MAX_IN.
- R10: busy_o rises on the accepted start edge and falls on the edge that raises done_o. A memory read only happens while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a run (ignored while busy) |
| n_inputs_i | input | 5 | Number of synapses N, clamped to MAX_IN |
| bias_i | input | 16 | Signed bias, sampled on start |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 5 | Memory read address |
| mem_rdata_i | input | 8 | Signed read data, one cycle after the read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle result strobe |
| y_o | output | 8 | Neuron output, held between runs |

## Verification
One bench case drives the sum into positive saturation and then subtracts. A design that wraps instead of clamping, or that sums all products at the end, would show a sharply different output. The zero-synapse case catches a design that issues stray reads, or that reports done with a stale or missing bias. Another case sends a second start pulse partway through a run. A design that re-arms on that pulse would restart the read addresses or move the done pulse. The remaining cases cover an oversized count, which must stop after 32 reads, and a sweep of biases across every segment edge of the transfer function, where a miswired slope or sign shows as a wrong output code.

// File: rtl/neuron_mac_pkg.sv
package neuron_mac_pkg;
  localparam int NEURON_OUT_W = 8;
  localparam int XFER_IDX_W   = 6;

  // magnitude above/below midscale for a given |index|
  function automatic int xfer_mag(input int a);
    if (a < 8)       return a * 12;
    else if (a < 16) return 96 + (a - 8) * 3;
    else             return 120 + ((a - 16) >> 1);
  endfunction
endpackage

// File: rtl/neuron_mac_fetch.sv
module neuron_mac_fetch #(
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [CNT_W-1:0]  n_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vld_o,
  output logic              phase_o,
  output logic              last_o
);
  logic              active_q, vld_q, phase_q, last_q;
  logic [ADDR_W-1:0] idx_q, last_idx;
  logic [ADDR_W:0]   span;

  assign span     = (ADDR_W+1)'(n_i) << 1;
  assign last_idx = span[ADDR_W-1:0] - ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      vld_q    <= 1'b0;
      phase_q  <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      vld_q   <= active_q;
      phase_q <= idx_q[0];
      last_q  <= active_q && (idx_q == last_idx);
      if (launch_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end else if (active_q) begin
        if (idx_q == last_idx) active_q <= 1'b0;
        else                   idx_q    <= idx_q + ADDR_W'(1);
      end
    end
  end

  assign rd_o    = active_q;
  assign addr_o  = idx_q;
  assign vld_o   = vld_q;
  assign phase_o = phase_q;
  assign last_o  = last_q;
endmodule

// File: rtl/neuron_mac_dp.sv
module neuron_mac_dp #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic signed [ACC_W-1:0]  bias_i,
  input  logic                     vld_i,
  input  logic                     phase_i,
  input  logic                     last_i,
  input  logic signed [DATA_W-1:0] rdata_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic                     fin_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [DATA_W-1:0] x_q;
  logic signed [PROD_W-1:0] prod_d, prod_q;
  logic                     pvld_q, plast_q, fin_q;
  logic signed [ACC_W-1:0]  acc_q, acc_sat;
  logic signed [ACC_W:0]    acc_x, prod_x, sum;

  // weight arrives straight from memory into the multiplier
  assign prod_d = x_q * rdata_i;
  assign acc_x  = {acc_q[ACC_W-1], acc_q};
  assign prod_x = {{(ACC_W+1-PROD_W){prod_q[PROD_W-1]}}, prod_q};
  assign sum    = acc_x + prod_x;

  always_comb begin
    if (sum[ACC_W] != sum[ACC_W-1]) acc_sat = sum[ACC_W] ? ACC_MIN : ACC_MAX;
    else                            acc_sat = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      prod_q  <= '0;
      pvld_q  <= 1'b0;
      plast_q <= 1'b0;
      acc_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      if (vld_i && !phase_i) x_q <= rdata_i;
      if (vld_i && phase_i)  prod_q <= prod_d;
      pvld_q  <= vld_i && phase_i;
      plast_q <= vld_i && phase_i && last_i;
      fin_q   <= pvld_q && plast_q;
      if (load_i)      acc_q <= bias_i;
      else if (pvld_q) acc_q <= acc_sat;
    end
  end

  assign acc_o = acc_q;
  assign fin_o = fin_q;
endmodule

// File: rtl/neuron_mac_xfer.sv
module neuron_mac_xfer
  import neuron_mac_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic [NEURON_OUT_W-1:0]  y_o
);
  logic signed [XFER_IDX_W-1:0] idx;
  logic                         unused_low;

  assign idx        = acc_i[ACC_W-1 -: XFER_IDX_W];
  assign unused_low = ^acc_i[ACC_W-XFER_IDX_W-1:0];

  always_comb begin
    int v, mag;
    v   = int'(idx);
    mag = xfer_mag((v < 0) ? -v : v);
    y_o = NEURON_OUT_W'((v < 0) ? (128 - mag) : (128 + mag));
  end
endmodule

// File: rtl/neuron_mac.sv
module neuron_mac
  import neuron_mac_pkg::*;
#(
  parameter  int MAX_IN = 16,
  parameter  int DATA_W = 8,
  parameter  int ACC_W  = 16,
  localparam int CNT_W  = $clog2(MAX_IN + 1),
  localparam int ADDR_W = $clog2(2 * MAX_IN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         n_inputs_i,
  input  logic signed [ACC_W-1:0]  bias_i,
  output logic                     mem_rd_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic signed [DATA_W-1:0] mem_rdata_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [NEURON_OUT_W-1:0]  y_o
);
  logic                    busy_q, done_q, zero_fin_q, launch, dp_fin, fin_any;
  logic [CNT_W-1:0]        n_clamp, n_q;
  logic signed [ACC_W-1:0] acc;
  logic [NEURON_OUT_W-1:0] y_q, y_d;
  logic                    f_vld, f_phase, f_last;

  assign launch  = start_i && !busy_q;
  assign n_clamp = (n_inputs_i > CNT_W'(MAX_IN)) ? CNT_W'(MAX_IN) : n_inputs_i;
  assign fin_any = dp_fin || zero_fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      zero_fin_q <= 1'b0;
      n_q        <= '0;
      y_q        <= '0;
    end else begin
      zero_fin_q <= launch && (n_clamp == '0);
      done_q     <= fin_any;
      if (launch) begin
        busy_q <= 1'b1;
        n_q    <= n_clamp;
      end else if (fin_any) begin
        busy_q <= 1'b0;
      end
      if (fin_any) y_q <= y_d;
    end
  end

  neuron_mac_fetch #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch && (n_clamp != '0)),
    .n_i      (n_q),
    .rd_o     (mem_rd_o),
    .addr_o   (mem_addr_o),
    .vld_o    (f_vld),
    .phase_o  (f_phase),
    .last_o   (f_last)
  );

  neuron_mac_dp #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (launch),
    .bias_i  (bias_i),
    .vld_i   (f_vld),
    .phase_i (f_phase),
    .last_i  (f_last),
    .rdata_i (mem_rdata_i),
    .acc_o   (acc),
    .fin_o   (dp_fin)
  );

  neuron_mac_xfer #(.ACC_W(ACC_W)) u_xfer (
    .acc_i (acc),
    .y_o   (y_d)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign y_o    = y_q;
endmodule

// File: rtl/neuron_mac_chk.sv
module neuron_mac_chk #(
  parameter int ADDR_W = 5,
  parameter int OUT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [OUT_W-1:0]  y_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_Y_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(y_o)); // R6
  AST_FIRST_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_rd_o) |-> mem_addr_o == '0); // R2
  AST_ADDR_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && $past(mem_rd_o) |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)); // R2
  AST_READ_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o); // R10
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
endmodule

bind neuron_mac neuron_mac_chk #(
  .ADDR_W (ADDR_W),
  .OUT_W  (neuron_mac_pkg::NEURON_OUT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .y_o        (y_o)
);

// File: tb/neuron_mac_tb_top.sv
module neuron_mac_tb_top;
  localparam int MAX_IN = 16;
  localparam int CNT_W  = $clog2(MAX_IN + 1);
  localparam int ADDR_W = $clog2(2 * MAX_IN);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  n_in = '0;
  logic signed [15:0] bias_in = '0;
  logic              mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic signed [7:0] rdata;
  logic              busy, done;
  logic [7:0]        y;
  logic signed [7:0] mem [2*MAX_IN];
  int                n_checks = 0;
  int                n_fail = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (mem_rd) rdata <= mem[mem_addr];

  neuron_mac dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n_inputs_i(n_in), .bias_i(bias_in),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .y_o(y)
  );

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_acc(input int n, input int bias);
    int acc = bias;
    for (int k = 0; k < n; k++) begin
      acc = acc + int'(mem[2*k]) * int'(mem[2*k+1]);
      if (acc > 32767)  acc = 32767;
      if (acc < -32768) acc = -32768;
    end
    return acc;
  endfunction

  function automatic int model_y(input int acc);
    int v = acc >>> 10;
    int a = (v < 0) ? -v : v;
    int m = (a < 8) ? 12 * a : (a < 16) ? 96 + 3 * (a - 8) : 120 + ((a - 16) >> 1);
    return (v < 0) ? 128 - m : 128 + m;
  endfunction

  // one run; optional second start at negedge index intr_at
  task automatic run_case(input string tag, input int n_req, input int bias,
                          input int intr_at = -1);
    int n_eff = (n_req > MAX_IN) ? MAX_IN : n_req;
    int d = (n_eff == 0) ? 1 : 2 * n_eff + 3;
    int exp_y = model_y(model_acc(n_eff, bias));
    int rd_bad = 0, done_bad = 0, busy_bad = 0, y_at_done = -1;
    @(negedge clk);
    start = 1'b1; n_in = CNT_W'(n_req); bias_in = 16'(bias);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= d + 2; i++) begin
      if (mem_rd != (i < 2 * n_eff)) rd_bad++;
      else if (mem_rd && int'(mem_addr) != i) rd_bad++;
      if (done != (i == d)) done_bad++;
      if (busy != (i < d)) busy_bad++;
      if (i == d) y_at_done = int'(y);
      if (i == intr_at) begin
        start = 1'b1; n_in = CNT_W'(1); bias_in = 16'sd0;
      end else start = 1'b0;
      @(negedge clk);
    end
    check({tag, " R2 read sequence"}, rd_bad == 0, rd_bad, 0);
    check({tag, " R6 done timing"}, done_bad == 0, done_bad, 0);
    check({tag, " R10 busy window"}, busy_bad == 0, busy_bad, 0);
    check({tag, " output"}, y_at_done == exp_y, y_at_done, exp_y);
    check({tag, " R6 output held"}, int'(y) == exp_y, int'(y), exp_y);
  endtask

  task automatic t_reset;
    check("R1 reset idle", !busy && !done && !mem_rd && y == 8'd0,
          {busy, done, mem_rd, y}, 0);
  endtask

  task automatic t_basic;  // R3
    mem[0] = 100; mem[1] = 90; mem[2] = 50; mem[3] = -40; mem[4] = -20; mem[5] = 60;
    run_case("R3 basic", 3, 3000);
    mem[0] = -7; mem[1] = 120; mem[2] = 33; mem[3] = -99;
    mem[4] = 12; mem[5] = 11; mem[6] = -128; mem[7] = -128;
    run_case("R3 mixed signs", 4, -9000);
  endtask

  task automatic t_saturate;  // R4
    for (int k = 0; k < 3; k++) begin mem[2*k] = 127; mem[2*k+1] = 127; end
    mem[6] = -128; mem[7] = 127; mem[8] = -128; mem[9] = 127;
    run_case("R4 positive clamp", 5, 0);
    for (int k = 0; k < 2; k++) begin mem[2*k] = -128; mem[2*k+1] = 127; end
    mem[4] = 100; mem[5] = 100;
    run_case("R4 negative clamp", 3, -20000);
  endtask

  task automatic t_zero;  // R7
    run_case("R7 zero synapses", 0, 5000);
  endtask

  task automatic t_clamp;  // R9
    for (int k = 0; k < 2 * MAX_IN; k++) mem[k] = 8'(k * 5 - 70);
    run_case("R9 count clamp", 20, 1000);
  endtask

  task automatic t_restart;  // R8
    mem[0] = 60; mem[1] = 70; mem[2] = 50; mem[3] = 80; mem[4] = 40; mem[5] = 90;
    run_case("R8 start while busy", 3, 2000, 3);
  endtask

  task automatic t_xfer;  // R5, bias alone through the lookup
    int pts[9] = '{-32768, -8193, -1025, -1, 0, 1023, 8192, 16384, 32767};
    foreach (pts[j]) run_case("R5 transfer point", 0, pts[j]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2 * MAX_IN; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_saturate();
    t_zero();
    t_clamp();
    t_restart();
    t_xfer();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule